// File: doc/BRIEF.md
# Multi-Lane Serial Audio Port Engine

This block turns one core clock into the timing of a multi-lane serial audio port. It drives a bit clock, a word select and an oversampling clock that all lanes share. Every frame is 1024 core clocks long, so the sample rate is the core clock divided by 1024. Each output lane and each input lane carries one stereo pair per frame, in two 32-bit slots: the left slot first, then the right slot. With the default eight lanes, the block carries sixteen channels in each direction.

On the transmit side, the block takes one left and one right sample for each lane as parallel words, up to 22 bits wide. It captures them once per frame and shifts every lane out MSB first, all lanes in lockstep. Two data placements are available. The first is the standard delayed format, where the MSB follows the word-select edge by one bit. The second is a right-justified format, where the LSB lands on the last bit of the slot and the transmitted length is selectable. The receive side always takes 20-bit words in the placement chosen for the current frame. It sign-extends them to 24 bits and presents all lanes together with a one-clock frame-done strobe.

Top module: `mlane_i2s`

## Requirements
- R1: While reset is asserted, `bck_o`, `ws_o`, `mclk_o`, `sd_o` and `rx_done_o` are low and the receive outputs are zero. Every `sd_o` lane stays low for the whole first frame after reset.
- R2: Core clocks after reset release are counted from t=0. The bit clock is high exactly when (t mod 16) >= 8, which gives 64 bit periods in each 1024-clock frame.
- R3: `ws_o` is low during bit periods 0..31 of a frame (left slot) and high during bit periods 32..63 (right slot). It changes only on the edge where the bit clock falls, 8 core clocks after a rising edge.
- R4: `sd_o` changes only where the bit clock falls and carries one bit per bit period. Bit period k of a slot carries slot bit 31-k, so slot bit 31 goes out first.
- R5: With `fmt_i`=0 (delayed format), the 22-bit sample occupies slot bits 30..9, so its MSB sits in the second bit period of the slot. All other slot bits are zero.
- R6: With `fmt_i`=1 (right-justified), L = 16 + 2*`len_sel_i` (16, 18, 20 or 22). The top L bits of the sample fill slot bits L-1..0, so the sample's LSB ends the slot. The leading bits are zero.
- R7: The transmit samples, `fmt_i` and `len_sel_i` are captured only on the edge that starts a frame. Any change made during a frame affects the next frame and not the current one. The receive placement for a frame is the `fmt_i` captured at that frame's start.
- R8: Each `sd_i` lane is sampled once per bit period, on the core clock edge where the bit clock rises. Input values at other edges are ignored.
- R9: Received slots are decoded as 20 bits and sign-extended to 24. The delayed format takes slot bits 30..11 and the right-justified format takes bits 19..0. All other slot bits are ignored.
- R10: `rx_done_o` is high for exactly one core clock, the one after the last right-slot bit is sampled (frame position 1016). The left and right outputs of every lane update in that same cycle and hold at all other times.
- R11: `mclk_o` has a period of 4 core clocks (256 times the sample rate) and is high when (t mod 4) >= 2.

Top module parameters set the lane count and widths. The table below uses the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 1 | Data placement: 0 delayed format, 1 right-justified |
| len_sel_i | input | 2 | Right-justified transmit length: 16 + 2*value |
| tx_left_i | input | LANES*22 | Left transmit samples, lane n at bits n*22 +: 22 |
| tx_right_i | input | LANES*22 | Right transmit samples, same packing |
| sd_o | output | LANES | Serial data out, one bit per lane |
| sd_i | input | LANES | Serial data in, one bit per lane |
| rx_left_o | output | LANES*24 | Received left words, sign-extended, lane n at n*24 +: 24 |
| rx_right_o | output | LANES*24 | Received right words, same packing |
| rx_done_o | output | 1 | One-clock strobe: all receive words are new |
| bck_o | output | 1 | Bit clock, 16 core clocks per period |
| ws_o | output | 1 | Word select, low for the left slot |
| mclk_o | output | 1 | Oversampling clock, core clock divided by 4 |

## Verification
A wrong phase or bit count shows on `bck_o` or `ws_o` within one bit period, and it shifts every `sd_o` bit of the frame after it. An error in the transmit slot builder or the shadow capture shows as wrong bits on `sd_o` in the first frame after the faulty capture. A misaligned receive shift register or sampling point shows on the receive words at the next frame-done strobe, at most 1024 clocks later. The bench drives the correct input bit only at the one sampling edge in each bit period and inverted data at every other edge, so a receive sampling point that is off by one edge corrupts every received bit.

// File: rtl/mlane_i2s_pkg.sv
package mlane_i2s_pkg;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_RJ  = 1'b1
  } fmt_e;

  typedef struct packed {
    logic frame_end;    // last core clock of the frame
    logic bit_end;      // last core clock of a bit period
    logic sample;       // edge on which bck rises
    logic last_sample;  // sample edge of the final bit
  } tick_t;

endpackage

// File: rtl/mlane_i2s_timer.sv
module mlane_i2s_timer
  import mlane_i2s_pkg::*;
#(
  parameter int BCK_DIV  = 16,
  parameter int SLOT_W   = 32,
  parameter int MCLK_DIV = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  output tick_t tick_o,
  output logic  bck_o,
  output logic  ws_o,
  output logic  mclk_o
);

  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int PH_W       = $clog2(BCK_DIV);
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int MC_W       = $clog2(MCLK_DIV);
  localparam int HALF       = BCK_DIV / 2;
  localparam int MC_HALF    = MCLK_DIV / 2;

  logic [PH_W-1:0]  phase_q, phase_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [MC_W-1:0]  mc_q, mc_d;
  logic             bck_q, ws_q, mclk_q;
  logic             ph_wrap, bit_wrap;

  always_comb begin
    ph_wrap  = (phase_q == PH_W'(BCK_DIV - 1));
    bit_wrap = (bit_q == BIT_W'(FRAME_BITS - 1));
    phase_d  = ph_wrap ? '0 : phase_q + 1'b1;
    if (ph_wrap) bit_d = bit_wrap ? '0 : bit_q + 1'b1;
    else         bit_d = bit_q;
    mc_d     = (mc_q == MC_W'(MCLK_DIV - 1)) ? '0 : mc_q + 1'b1;
  end

  always_comb begin
    tick_o.frame_end   = ph_wrap && bit_wrap;
    tick_o.bit_end     = ph_wrap;
    tick_o.sample      = (phase_q == PH_W'(HALF - 1));
    tick_o.last_sample = (phase_q == PH_W'(HALF - 1)) && bit_wrap;
  end

  // outputs registered from next state so each is a plain flop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      bit_q   <= '0;
      mc_q    <= '0;
      bck_q   <= 1'b0;
      ws_q    <= 1'b0;
      mclk_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      mc_q    <= mc_d;
      bck_q   <= (phase_d >= PH_W'(HALF));
      ws_q    <= (bit_d >= BIT_W'(SLOT_W));
      mclk_q  <= (mc_d >= MC_W'(MC_HALF));
    end
  end

  assign bck_o  = bck_q;
  assign ws_o   = ws_q;
  assign mclk_o = mclk_q;

endmodule

// File: rtl/mlane_i2s_tx_lane.sv
module mlane_i2s_tx_lane
  import mlane_i2s_pkg::*;
#(
  parameter int SLOT_W   = 32,
  parameter int TX_W     = 22,
  parameter int RJ_MIN_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            shift_i,
  input  fmt_e            fmt_i,
  input  logic [1:0]      len_sel_i,
  input  logic [TX_W-1:0] left_i,
  input  logic [TX_W-1:0] right_i,
  output logic            sd_o
);

  localparam int FRAME_BITS = 2 * SLOT_W;

  function automatic logic [SLOT_W-1:0] place(input logic [TX_W-1:0] s,
                                              input fmt_e f,
                                              input logic [1:0] ls);
    logic [SLOT_W-1:0] w;
    int drop;
    drop = TX_W - RJ_MIN_W - 2 * int'(ls);
    if (f == FMT_I2S) w = {1'b0, s, {(SLOT_W - TX_W - 1){1'b0}}};
    else              w = SLOT_W'(s) >> drop;
    return w;
  endfunction

  // the shift register doubles as the per-frame shadow copy
  logic [FRAME_BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= {place(left_i, fmt_i, len_sel_i), place(right_i, fmt_i, len_sel_i)};
    else if (shift_i) sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
  end

  assign sd_o = sh_q[FRAME_BITS-1];

endmodule

// File: rtl/mlane_i2s_rx_lane.sv
module mlane_i2s_rx_lane
  import mlane_i2s_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int RX_W   = 20,
  parameter int RXO_W  = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             last_i,
  input  fmt_e             fmt_i,
  input  logic             sd_i,
  output logic [RXO_W-1:0] left_o,
  output logic [RXO_W-1:0] right_o
);

  localparam int FRAME_BITS = 2 * SLOT_W;

  function automatic logic [RXO_W-1:0] extract(input logic [SLOT_W-1:0] slot,
                                               input fmt_e f);
    logic [RX_W-1:0] v;
    v = (f == FMT_I2S) ? RX_W'(slot >> (SLOT_W - 1 - RX_W)) : RX_W'(slot);
    return {{(RXO_W - RX_W){v[RX_W-1]}}, v};
  endfunction

  logic [FRAME_BITS-2:0] sh_q;
  logic [FRAME_BITS-1:0] sh_d;
  logic [RXO_W-1:0]      left_q, right_q;

  assign sh_d = {sh_q, sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      left_q  <= '0;
      right_q <= '0;
    end else if (sample_i) begin
      sh_q <= sh_d[FRAME_BITS-2:0];
      if (last_i) begin
        left_q  <= extract(sh_d[FRAME_BITS-1:SLOT_W], fmt_i);
        right_q <= extract(sh_d[SLOT_W-1:0], fmt_i);
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;

endmodule

// File: rtl/mlane_i2s.sv
module mlane_i2s
  import mlane_i2s_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int SLOT_W   = 32,
  parameter int TX_W     = 22,
  parameter int RJ_MIN_W = 16,
  parameter int RX_W     = 20,
  parameter int RXO_W    = 24,
  parameter int BCK_DIV  = 16,
  parameter int MCLK_DIV = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fmt_i,
  input  logic [1:0]             len_sel_i,
  input  logic [LANES*TX_W-1:0]  tx_left_i,
  input  logic [LANES*TX_W-1:0]  tx_right_i,
  output logic [LANES-1:0]       sd_o,
  input  logic [LANES-1:0]       sd_i,
  output logic [LANES*RXO_W-1:0] rx_left_o,
  output logic [LANES*RXO_W-1:0] rx_right_o,
  output logic                   rx_done_o,
  output logic                   bck_o,
  output logic                   ws_o,
  output logic                   mclk_o
);

  tick_t tick;
  fmt_e  fmt_in, fmt_q;
  logic  done_q;

  assign fmt_in = fmt_e'(fmt_i);

  mlane_i2s_timer #(
    .BCK_DIV (BCK_DIV),
    .SLOT_W  (SLOT_W),
    .MCLK_DIV(MCLK_DIV)
  ) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick),
    .bck_o (bck_o),
    .ws_o  (ws_o),
    .mclk_o(mclk_o)
  );

  // receive placement follows the format captured at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= FMT_I2S;
      done_q <= 1'b0;
    end else begin
      if (tick.frame_end) fmt_q <= fmt_in;
      done_q <= tick.last_sample;
    end
  end

  assign rx_done_o = done_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mlane_i2s_tx_lane #(
      .SLOT_W  (SLOT_W),
      .TX_W    (TX_W),
      .RJ_MIN_W(RJ_MIN_W)
    ) i_tx (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (tick.frame_end),
      .shift_i  (tick.bit_end),
      .fmt_i    (fmt_in),
      .len_sel_i(len_sel_i),
      .left_i   (tx_left_i[g*TX_W +: TX_W]),
      .right_i  (tx_right_i[g*TX_W +: TX_W]),
      .sd_o     (sd_o[g])
    );

    mlane_i2s_rx_lane #(
      .SLOT_W(SLOT_W),
      .RX_W  (RX_W),
      .RXO_W (RXO_W)
    ) i_rx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sample_i(tick.sample),
      .last_i  (tick.last_sample),
      .fmt_i   (fmt_q),
      .sd_i    (sd_i[g]),
      .left_o  (rx_left_o[g*RXO_W +: RXO_W]),
      .right_o (rx_right_o[g*RXO_W +: RXO_W])
    );
  end

endmodule

// File: rtl/mlane_i2s_chk.sv
module mlane_i2s_chk #(
  parameter int LANES   = 8,
  parameter int RXO_W   = 24,
  parameter int BCK_DIV = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   bck_o,
  input logic                   ws_o,
  input logic                   mclk_o,
  input logic [LANES-1:0]       sd_o,
  input logic                   rx_done_o,
  input logic [LANES*RXO_W-1:0] rx_left_o,
  input logic [LANES*RXO_W-1:0] rx_right_o
);

  localparam int HALF  = BCK_DIV / 2;
  localparam int CNT_W = $clog2(BCK_DIV) + 1;

  logic             bck_prev;
  logic [CNT_W-1:0] lvl_cnt;

  // run length of the current bit-clock level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_prev <= 1'b0;
      lvl_cnt  <= '0;
    end else begin
      bck_prev <= bck_o;
      lvl_cnt  <= (bck_o != bck_prev) ? CNT_W'(1) : lvl_cnt + 1'b1;
    end
  end

  p_bck_half_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bck_o != bck_prev) |-> (lvl_cnt == CNT_W'(HALF)));

  p_ws_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $fell(bck_o));

  p_sd_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $fell(bck_o));

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);

  p_done_in_right_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> (ws_o && bck_o));

  p_rx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_done_o |-> ($stable(rx_left_o) && $stable(rx_right_o)));

  p_mclk_shape_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mclk_o) |=> mclk_o ##1 !mclk_o);

endmodule

bind mlane_i2s mlane_i2s_chk #(
  .LANES  (LANES),
  .RXO_W  (RXO_W),
  .BCK_DIV(BCK_DIV)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bck_o     (bck_o),
  .ws_o      (ws_o),
  .mclk_o    (mclk_o),
  .sd_o      (sd_o),
  .rx_done_o (rx_done_o),
  .rx_left_o (rx_left_o),
  .rx_right_o(rx_right_o)
);

// File: tb/test_mlane_i2s.sv
module test_mlane_i2s;

  localparam int LANES   = 8;
  localparam int TX_W    = 22;
  localparam int RX_W    = 20;
  localparam int RXO_W   = 24;
  localparam int FRAME   = 1024;
  localparam int NFRAMES = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                   fmt;
  logic [1:0]             len_sel;
  logic [LANES*TX_W-1:0]  tx_left, tx_right;
  logic [LANES-1:0]       sd_out, sd_in;
  logic [LANES*RXO_W-1:0] rx_left, rx_right;
  logic                   rx_done, bck, ws, mclk;

  mlane_i2s i_mlane_i2s (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .fmt_i     (fmt),
    .len_sel_i (len_sel),
    .tx_left_i (tx_left),
    .tx_right_i(tx_right),
    .sd_o      (sd_out),
    .sd_i      (sd_in),
    .rx_left_o (rx_left),
    .rx_right_o(rx_right),
    .rx_done_o (rx_done),
    .bck_o     (bck),
    .ws_o      (ws),
    .mclk_o    (mclk)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit run_done = 1'b0;

  logic [TX_W-1:0]  drv_l [LANES], drv_r [LANES], cur_l [LANES], cur_r [LANES];
  logic             cur_fmt;
  logic [1:0]       cur_len;
  logic [RXO_W-1:0] held_l [LANES], held_r [LANES];

  always_comb begin
    for (int ln = 0; ln < LANES; ln++) begin
      tx_left[ln*TX_W +: TX_W]  = drv_l[ln];
      tx_right[ln*TX_W +: TX_W] = drv_r[ln];
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [TX_W-1:0] txpat(int f, int ln, int ch, int kind);
    logic [31:0] h;
    h = (32'(f) * 32'h9E3779B1) ^ (32'(ln + 3) * 32'h85EBCA6B) ^ (32'(ch + 1) * 32'hC2B2AE35);
    case (kind)
      0:       return TX_W'(h);
      1:       return TX_W'(h >> 7);
      default: return (ln % 2 == 1) ? {TX_W{1'b1}} : {1'b1, {(TX_W-2){1'b0}}, 1'b1};
    endcase
  endfunction

  function automatic logic [31:0] rxword(int f, int ln, int ch);
    return (32'(f * 7 + ln) * 32'h2545F491) ^ (32'(ch + 5) * 32'h9E3779B9) ^ 32'(f);
  endfunction

  // slot construction from the requirement text
  function automatic logic [31:0] slot_ref(logic [TX_W-1:0] s, logic f, logic [1:0] ls);
    int l;
    if (f == 1'b0) return {1'b0, s, 9'b0};
    l = 16 + 2 * int'(ls);
    return 32'(s) >> (22 - l);
  endfunction

  function automatic logic [RXO_W-1:0] rx_ref(logic [31:0] w, logic f);
    logic [RX_W-1:0] v;
    v = f ? w[19:0] : w[30:11];
    return {{(RXO_W-RX_W){v[RX_W-1]}}, v};
  endfunction

  task automatic set_cfg(int g, bit garbage);
    int idx, kind;
    idx  = g - 1;
    kind = (idx / 8) % 3;
    for (int ln = 0; ln < LANES; ln++) begin
      drv_l[ln] = garbage ? ~txpat(g, ln, 0, kind) : txpat(g, ln, 0, kind);
      drv_r[ln] = garbage ? ~txpat(g, ln, 1, kind) : txpat(g, ln, 1, kind);
    end
    fmt     = garbage ? ~1'((idx / 4) % 2) : 1'((idx / 4) % 2);
    len_sel = garbage ? 2'(idx % 4 + 1) : 2'(idx % 4);
  endtask

  task automatic step(int t);
    int f, pos, ph, b;
    logic [31:0] w;
    logic e;
    f   = t / FRAME;
    pos = t % FRAME;
    ph  = pos % 16;
    b   = pos / 16;
    if (pos == 0 && t > 0) begin
      for (int ln = 0; ln < LANES; ln++) begin
        cur_l[ln] = drv_l[ln];
        cur_r[ln] = drv_r[ln];
      end
      cur_fmt = fmt;
      cur_len = len_sel;
    end
    chk(bck == (ph >= 8), "R2 bit clock level", 64'(bck), 64'(ph >= 8));
    chk(ws == (b >= 32), "R3 word select level", 64'(ws), 64'(b >= 32));
    chk(mclk == ((t % 4) >= 2), "R11 oversampling clock", 64'(mclk), 64'((t % 4) >= 2));
    for (int ln = 0; ln < LANES; ln++) begin
      if (f == 0) begin
        chk(sd_out[ln] == 1'b0, "R1 first frame silent", 64'(sd_out[ln]), 64'd0);
      end else begin
        w = slot_ref(b < 32 ? cur_l[ln] : cur_r[ln], cur_fmt, cur_len);
        e = w[31 - (b % 32)];
        chk(sd_out[ln] == e, cur_fmt ? "R4 R6 R7 tx right-justified bit" : "R4 R5 R7 tx delayed bit",
            64'(sd_out[ln]), 64'(e));
      end
    end
    chk(rx_done == (pos == 1016), "R10 done strobe timing", 64'(rx_done), 64'(pos == 1016));
    if (pos == 1016) begin
      for (int ln = 0; ln < LANES; ln++) begin
        held_l[ln] = rx_ref(rxword(f, ln, 0), cur_fmt);
        held_r[ln] = rx_ref(rxword(f, ln, 1), cur_fmt);
        chk(rx_left[ln*RXO_W +: RXO_W] == held_l[ln], "R8 R9 R10 rx left word",
            64'(rx_left[ln*RXO_W +: RXO_W]), 64'(held_l[ln]));
        chk(rx_right[ln*RXO_W +: RXO_W] == held_r[ln], "R8 R9 R10 rx right word",
            64'(rx_right[ln*RXO_W +: RXO_W]), 64'(held_r[ln]));
      end
    end
    if (pos == 500) begin
      for (int ln = 0; ln < LANES; ln++) begin
        chk(rx_left[ln*RXO_W +: RXO_W] == held_l[ln], "R1 R10 rx left hold",
            64'(rx_left[ln*RXO_W +: RXO_W]), 64'(held_l[ln]));
        chk(rx_right[ln*RXO_W +: RXO_W] == held_r[ln], "R1 R10 rx right hold",
            64'(rx_right[ln*RXO_W +: RXO_W]), 64'(held_r[ln]));
      end
    end
    // R7: junk early in the frame, real settings later; only the last one counts
    if (pos == 200) set_cfg(f + 1, 1'b1);
    if (pos == 600) set_cfg(f + 1, 1'b0);
    // R8: correct bit only ahead of the rising bit-clock edge, inverted elsewhere
    for (int ln = 0; ln < LANES; ln++) begin
      w = rxword(f, ln, b < 32 ? 0 : 1);
      e = w[31 - (b % 32)];
      sd_in[ln] = (ph == 7) ? e : ~e;
    end
  endtask

  initial begin
    for (int ln = 0; ln < LANES; ln++) begin
      drv_l[ln]  = '0;
      drv_r[ln]  = '0;
      cur_l[ln]  = '0;
      cur_r[ln]  = '0;
      held_l[ln] = '0;
      held_r[ln] = '0;
    end
    fmt     = 1'b0;
    len_sel = 2'd0;
    cur_fmt = 1'b0;
    cur_len = 2'd0;
    sd_in   = '0;
    repeat (3) @(negedge clk);
    chk(bck == 1'b0, "R1 reset bit clock", 64'(bck), 64'd0);
    chk(ws == 1'b0, "R1 reset word select", 64'(ws), 64'd0);
    chk(mclk == 1'b0, "R1 reset oversampling clock", 64'(mclk), 64'd0);
    chk(sd_out == '0, "R1 reset serial out", 64'(sd_out), 64'd0);
    chk(rx_done == 1'b0, "R1 reset done", 64'(rx_done), 64'd0);
    chk(rx_left == '0 && rx_right == '0, "R1 reset rx words", 64'(rx_left ^ rx_right), 64'd0);
    rst_n = 1'b1;
    step(0);
    for (int t = 1; t < NFRAMES * FRAME; t++) begin
      @(negedge clk);
      step(t);
    end
    run_done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!run_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule